// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address. It walks a three-level radix tree of 4 KiB page tables, and the root page number of that tree comes in on an input port. Each table holds 512 eight-byte entries. The walker fetches one entry per level over a simple request/response memory port, descends through pointer entries, and runs a permission check on the leaf it finds. It then reports either a physical address together with the level of the leaf, or a fault code.

A leaf may sit at any of the three levels, which gives 4 KiB, 2 MiB or 1 GiB pages. For the larger pages, the page-number fields below the leaf level are taken from the virtual address. Accessed and dirty bits are never written. A clear A bit, or a store to a page whose D bit is clear, is reported as a page fault so that software can handle it. Only one walk runs at a time.

Top module: `vtrans_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mreq_valid_o` are low, and `fault_o` is 0.
- R2: `start_i` is taken only while `busy_o` is low. A start pulse during a walk changes neither that walk's result nor the number of reads it makes.
- R3: The walk starts at level 2. The first read address is root_ppn·4096 + vaddr[38:30]·8. Every read is one 8-byte-aligned request that is valid for a single cycle.
- R4: An entry with V=1 and R=X=0 is a pointer. The walker then reads entry_ppn·4096 + vpn[i−1]·8. The entry layout is: V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, A bit 6, D bit 7, PPN bits 53:10, and reserved bits 63:54.
- R5: A pointer found at level 0 gives a page fault. The fault code is 1.
- R6: Each of the following gives a page fault: V=0; W=1 with R=0; any nonzero bit in 63:54; a pointer with any of U, A or D set.
- R7: An error response on any read gives an access fault with code 2, and no further read is issued.
- R8: A good leaf gives `fault_o`=0 and sets `level_o` to the leaf level. The address is formed as follows: the offset bits 11:0 come from the virtual address; PPN fields below the leaf level come from the VPN; the rest comes from the entry.
- R9: A leaf at level 2 with PPN[17:0]≠0, or at level 1 with PPN[8:0]≠0, gives a page fault.
- R10: The privilege rules are:
  - In user mode (`umode_i`=1), a page with U=0 faults.
  - In supervisor mode, a page with U=1 faults unless `sum_i`=1 and the access is not a fetch.
- R11: The access type is coded as load=0, store=1, fetch=2.
  - A load needs R, or X when `mxr_i`=1.
  - A store needs W.
  - A fetch needs X.
  - Otherwise the walk page-faults.
- R12: A leaf with A=0, or a store to a leaf with D=0, page-faults.
- R13: `done_o` is a one-cycle pulse, and `paddr_o` is 0 on any fault. When each response arrives the cycle after its request, `done_o` rises 3n+1 cycles after the start cycle, where n is the number of reads.
- R14: A walk issues at most three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 39 | Virtual address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| umode_i | input | 1 | Access made in user mode |
| sum_i | input | 1 | Supervisor may touch user pages |
| mxr_i | input | 1 | Loads may read execute-only pages |
| root_ppn_i | input | 44 | Root table page number |
| busy_o | output | 1 | Walk in progress |
| mreq_valid_o | output | 1 | Entry read request (single cycle) |
| mreq_addr_o | output | 56 | Entry byte address |
| mresp_valid_i | input | 1 | Read response valid |
| mresp_err_i | input | 1 | Read response is an error |
| mresp_data_i | input | 64 | Entry read back |
| done_o | output | 1 | Result pulse |
| fault_o | output | 2 | 0 none, 1 page fault, 2 access fault |
| paddr_o | output | 56 | Physical address (0 on fault) |
| level_o | output | 2 | Level at which the walk ended |

## Verification
The bench aims at the following corner cases:

- **Superpage merging.** A wrong merge would put entry bits into the low page-number fields where VPN bits belong, or the reverse.
- **Misalignment.** A superpage leaf with stray low PPN bits must fault. A lax check would instead return a silently aliased address.
- **Pointer at level 0.** Without the bottom-of-tree test the walker would either fetch a fourth entry or report a bogus translation.
- **Error responses.** A walker that mixes up fault classes would report a bad read as a page fault or keep walking.
- **Permission and A/D rules.** The bench runs the U/SUM/MXR combinations and the store-without-dirty case, where an inverted term lets a forbidden access through.
- **Start pulse mid-walk.** This catches a walker that restarts or takes the new address.

// File: rtl/vtrans_pkg.sv
package vtrans_pkg;

   localparam int unsigned FLAG_W      = 10;
   localparam int unsigned BIT_V       = 0;
   localparam int unsigned BIT_R       = 1;
   localparam int unsigned BIT_W       = 2;
   localparam int unsigned BIT_X       = 3;
   localparam int unsigned BIT_U       = 4;
   localparam int unsigned BIT_A       = 6;
   localparam int unsigned BIT_D       = 7;
   localparam int unsigned ENTRY_LOG2  = 3;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_PAGE   = 2'd1,
      FLT_ACCESS = 2'd2
   } flt_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_CHECK = 2'd3
   } st_e;

endpackage

// File: rtl/vtrans_entry_chk.sv
module vtrans_entry_chk
   import vtrans_pkg::*;
#(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned VPN_W  = 9,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned PTE_W  = 64,
   parameter int unsigned LVL_W  = 2
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [LVL_W-1:0] lvl,
   input  logic [1:0]       acc,
   input  logic             umode,
   input  logic             sum,
   input  logic             mxr,
   output logic             descend,
   output logic             pfault
);
   localparam int unsigned RSV_W = PTE_W - PPN_W - FLAG_W;

   logic              v, r, w, x, u, a, d;
   logic [PPN_W-1:0]  ppn;
   logic              rsv_bad;
   logic [LEVELS-1:0] mis;
   logic              bad_enc, leaf, ptr_bad, priv_bad, perm_ok, ad_bad, leaf_bad;

   assign v   = pte[BIT_V];
   assign r   = pte[BIT_R];
   assign w   = pte[BIT_W];
   assign x   = pte[BIT_X];
   assign u   = pte[BIT_U];
   assign a   = pte[BIT_A];
   assign d   = pte[BIT_D];
   assign ppn = pte[FLAG_W +: PPN_W];

   if (RSV_W > 0) begin : g_rsv
      assign rsv_bad = |pte[PTE_W-1 -: RSV_W];
   end else begin : g_norsv
      assign rsv_bad = 1'b0;
   end

   assign mis[0] = 1'b0;
   for (genvar j = 1; j < LEVELS; j++) begin : g_mis
      assign mis[j] = (lvl == LVL_W'(j)) && (|ppn[j*VPN_W-1:0]);
   end

   assign bad_enc  = !v || (w && !r) || rsv_bad;
   assign leaf     = r || x;
   assign ptr_bad  = u || a || d || (lvl == '0);
   assign priv_bad = umode ? !u : (u && (!sum || acc == ACC_FETCH));

   always_comb begin
      unique case (acc)
         ACC_LOAD:  perm_ok = r || (mxr && x);
         ACC_STORE: perm_ok = w;
         ACC_FETCH: perm_ok = x;
         default:   perm_ok = 1'b0;
      endcase
   end

   assign ad_bad   = !a || (acc == ACC_STORE && !d);
   assign leaf_bad = (|mis) || priv_bad || !perm_ok || ad_bad;
   assign pfault   = bad_enc || (leaf ? leaf_bad : ptr_bad);
   assign descend  = !bad_enc && !leaf && !ptr_bad;

endmodule

// File: rtl/vtrans_pa_merge.sv
module vtrans_pa_merge #(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned VPN_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned LVL_W  = 2,
   localparam int unsigned VA_W  = LEVELS*VPN_W + OFF_W,
   localparam int unsigned PA_W  = PPN_W + OFF_W
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PPN_W-1:0] ppn,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  pa
);
   assign pa[OFF_W-1:0] = va[OFF_W-1:0];

   for (genvar j = 0; j < LEVELS; j++) begin : g_fld
      localparam int unsigned LO = j*VPN_W;
      if (j == LEVELS-1) begin : g_top
         assign pa[OFF_W+LO +: PPN_W-LO] = ppn[LO +: PPN_W-LO];
      end else begin : g_low
         assign pa[OFF_W+LO +: VPN_W] = (LVL_W'(j) < lvl) ? va[OFF_W+LO +: VPN_W]
                                                         : ppn[LO +: VPN_W];
      end
   end

endmodule

// File: rtl/vtrans_walk_fsm.sv
module vtrans_walk_fsm
   import vtrans_pkg::*;
#(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned VPN_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned PTE_W  = 64,
   parameter int unsigned LVL_W  = 2,
   localparam int unsigned VA_W  = LEVELS*VPN_W + OFF_W,
   localparam int unsigned PA_W  = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VA_W-1:0]  vaddr_i,
   input  logic [1:0]       acc_i,
   input  logic             umode_i,
   input  logic             sum_i,
   input  logic             mxr_i,
   input  logic [PPN_W-1:0] root_ppn_i,
   input  logic             rsp_valid_i,
   input  logic             rsp_err_i,
   input  logic [PTE_W-1:0] rsp_data_i,
   input  logic             descend_i,
   input  logic             pfault_i,
   input  logic [PA_W-1:0]  pa_merged_i,
   output logic [PTE_W-1:0] pte_q,
   output logic [LVL_W-1:0] lvl_q,
   output logic [VA_W-1:0]  va_q,
   output logic [1:0]       acc_q,
   output logic             umode_q,
   output logic             sum_q,
   output logic             mxr_q,
   output logic             busy_o,
   output logic             req_valid_o,
   output logic [PA_W-1:0]  req_addr_o,
   output logic             done_o,
   output logic [1:0]       fault_o,
   output logic [PA_W-1:0]  paddr_o,
   output logic [LVL_W-1:0] level_o
);
   st_e              st;
   logic [PPN_W-1:0] tbl_q;
   logic             err_q;
   logic [VPN_W-1:0] vpn_sel;

   assign vpn_sel     = va_q[OFF_W + int'(lvl_q)*VPN_W +: VPN_W];
   assign req_addr_o  = {tbl_q, vpn_sel, {ENTRY_LOG2{1'b0}}};
   assign req_valid_o = (st == ST_ISSUE);
   assign busy_o      = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         tbl_q   <= '0;
         lvl_q   <= '0;
         pte_q   <= '0;
         err_q   <= 1'b0;
         va_q    <= '0;
         acc_q   <= '0;
         umode_q <= 1'b0;
         sum_q   <= 1'b0;
         mxr_q   <= 1'b0;
         done_o  <= 1'b0;
         fault_o <= FLT_NONE;
         paddr_o <= '0;
         level_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  tbl_q   <= root_ppn_i;
                  lvl_q   <= LVL_W'(LEVELS-1);
                  va_q    <= vaddr_i;
                  acc_q   <= acc_i;
                  umode_q <= umode_i;
                  sum_q   <= sum_i;
                  mxr_q   <= mxr_i;
                  st      <= ST_ISSUE;
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  pte_q <= rsp_data_i;
                  err_q <= rsp_err_i;
                  st    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!err_q && descend_i) begin
                  tbl_q <= pte_q[FLAG_W +: PPN_W];
                  lvl_q <= lvl_q - 1'b1;
                  st    <= ST_ISSUE;
               end else begin
                  st      <= ST_IDLE;
                  done_o  <= 1'b1;
                  level_o <= lvl_q;
                  if (err_q) begin
                     fault_o <= FLT_ACCESS;
                     paddr_o <= '0;
                  end else if (pfault_i) begin
                     fault_o <= FLT_PAGE;
                     paddr_o <= '0;
                  end else begin
                     fault_o <= FLT_NONE;
                     paddr_o <= pa_merged_i;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vtrans_walker.sv
module vtrans_walker
   import vtrans_pkg::*;
#(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned VPN_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned PTE_W  = 64,
   localparam int unsigned LVL_W = (LEVELS > 2) ? $clog2(LEVELS) : 1,
   localparam int unsigned VA_W  = LEVELS*VPN_W + OFF_W,
   localparam int unsigned PA_W  = PPN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VA_W-1:0]  vaddr_i,
   input  logic [1:0]       acc_i,
   input  logic             umode_i,
   input  logic             sum_i,
   input  logic             mxr_i,
   input  logic [PPN_W-1:0] root_ppn_i,
   output logic             busy_o,
   output logic             mreq_valid_o,
   output logic [PA_W-1:0]  mreq_addr_o,
   input  logic             mresp_valid_i,
   input  logic             mresp_err_i,
   input  logic [PTE_W-1:0] mresp_data_i,
   output logic             done_o,
   output logic [1:0]       fault_o,
   output logic [PA_W-1:0]  paddr_o,
   output logic [LVL_W-1:0] level_o
);
   if (OFF_W != VPN_W + ENTRY_LOG2) begin : g_bad_off
      $error("table must be one page: OFF_W must equal VPN_W + 3");
   end
   if (PTE_W < PPN_W + FLAG_W) begin : g_bad_pte
      $error("entry too narrow for PPN and flags");
   end
   if (LEVELS < 2 || PPN_W < (LEVELS-1)*VPN_W) begin : g_bad_lvl
      $error("unsupported level count or PPN width");
   end

   logic [PTE_W-1:0] pte_q;
   logic [LVL_W-1:0] lvl_q;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       acc_q;
   logic             umode_q, sum_q, mxr_q;
   logic             descend, pfault;
   logic [PA_W-1:0]  pa_merged;

   vtrans_walk_fsm #(
      .LEVELS(LEVELS), .VPN_W(VPN_W), .OFF_W(OFF_W),
      .PPN_W(PPN_W), .PTE_W(PTE_W), .LVL_W(LVL_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .vaddr_i     (vaddr_i),
      .acc_i       (acc_i),
      .umode_i     (umode_i),
      .sum_i       (sum_i),
      .mxr_i       (mxr_i),
      .root_ppn_i  (root_ppn_i),
      .rsp_valid_i (mresp_valid_i),
      .rsp_err_i   (mresp_err_i),
      .rsp_data_i  (mresp_data_i),
      .descend_i   (descend),
      .pfault_i    (pfault),
      .pa_merged_i (pa_merged),
      .pte_q       (pte_q),
      .lvl_q       (lvl_q),
      .va_q        (va_q),
      .acc_q       (acc_q),
      .umode_q     (umode_q),
      .sum_q       (sum_q),
      .mxr_q       (mxr_q),
      .busy_o      (busy_o),
      .req_valid_o (mreq_valid_o),
      .req_addr_o  (mreq_addr_o),
      .done_o      (done_o),
      .fault_o     (fault_o),
      .paddr_o     (paddr_o),
      .level_o     (level_o)
   );

   vtrans_entry_chk #(
      .LEVELS(LEVELS), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .PTE_W(PTE_W), .LVL_W(LVL_W)
   ) u_chk (
      .pte     (pte_q),
      .lvl     (lvl_q),
      .acc     (acc_q),
      .umode   (umode_q),
      .sum     (sum_q),
      .mxr     (mxr_q),
      .descend (descend),
      .pfault  (pfault)
   );

   vtrans_pa_merge #(
      .LEVELS(LEVELS), .VPN_W(VPN_W), .OFF_W(OFF_W),
      .PPN_W(PPN_W), .LVL_W(LVL_W)
   ) u_merge (
      .va  (va_q),
      .ppn (pte_q[FLAG_W +: PPN_W]),
      .lvl (lvl_q),
      .pa  (pa_merged)
   );

endmodule

// File: rtl/vtrans_walker_chk.sv
module vtrans_walker_chk #(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned VPN_W  = 9,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned PPN_W  = 44,
   parameter int unsigned PTE_W  = 64,
   localparam int unsigned LVL_W = (LEVELS > 2) ? $clog2(LEVELS) : 1,
   localparam int unsigned VA_W  = LEVELS*VPN_W + OFF_W,
   localparam int unsigned PA_W  = PPN_W + OFF_W,
   localparam int unsigned SP_W  = (LEVELS-1)*VPN_W + OFF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [VA_W-1:0]  vaddr_i,
   input logic             busy_o,
   input logic             mreq_valid_o,
   input logic [PA_W-1:0]  mreq_addr_o,
   input logic             mresp_valid_i,
   input logic             mresp_err_i,
   input logic             done_o,
   input logic [1:0]       fault_o,
   input logic [PA_W-1:0]  paddr_o,
   input logic [LVL_W-1:0] level_o
);
   logic [VA_W-1:0] va_cap;
   logic [3:0]      rd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_cap <= '0;
         rd_cnt <= '0;
      end else if (start_i && !busy_o) begin
         va_cap <= vaddr_i;
         rd_cnt <= '0;
      end else if (mreq_valid_o) begin
         rd_cnt <= rd_cnt + 1'b1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mreq_valid_o);

   assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid_o |-> mreq_addr_o[2:0] == 3'b000);

   assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid_o |=> !mreq_valid_o);

   assert_err_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && mresp_valid_i && mresp_err_i) |=> ##1 (done_o && fault_o == 2'd2));

   assert_giga_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o == 2'd0 && level_o == LVL_W'(LEVELS-1))
         |-> paddr_o[SP_W-1:0] == va_cap[SP_W-1:0]);

   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_fault_zero_pa_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != 2'd0) |-> paddr_o == '0);

   assert_read_limit_R14: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid_o |-> rd_cnt < 4'(LEVELS));

endmodule

bind vtrans_walker vtrans_walker_chk #(
   .LEVELS(LEVELS), .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
) u_walker_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .vaddr_i       (vaddr_i),
   .busy_o        (busy_o),
   .mreq_valid_o  (mreq_valid_o),
   .mreq_addr_o   (mreq_addr_o),
   .mresp_valid_i (mresp_valid_i),
   .mresp_err_i   (mresp_err_i),
   .done_o        (done_o),
   .fault_o       (fault_o),
   .paddr_o       (paddr_o),
   .level_o       (level_o)
);

// File: tb/sim_vtrans_walker.sv
`timescale 1ns/1ps
module sim_vtrans_walker;
   localparam logic [43:0] ROOT = 44'h100;
   localparam logic [43:0] TL1  = 44'h200;
   localparam logic [43:0] TL0  = 44'h300;
   localparam int FV = 1, FR = 2, FW = 4, FX = 8, FU = 16, FA = 64, FD = 128;
   localparam int FULL = FV|FR|FW|FX|FA|FD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [38:0] vaddr_i = '0;
   logic [1:0]  acc_i = 2'd0;
   logic        umode_i = 1'b0, sum_i = 1'b0, mxr_i = 1'b0;
   logic [43:0] root_ppn_i = ROOT;
   logic        busy_o, mreq_valid_o, done_o;
   logic [55:0] mreq_addr_o, paddr_o;
   logic        mresp_valid_i = 1'b0, mresp_err_i = 1'b0;
   logic [63:0] mresp_data_i = '0;
   logic [1:0]  fault_o, level_o;

   int nchk = 0, nerr = 0;
   logic [63:0] mem [logic [55:0]];
   logic [55:0] err_addr = '1;
   int          nreads;
   logic [55:0] raddr [0:3];
   logic [1:0]  r_fault, r_lvl;
   logic [55:0] r_pa;
   int          r_cyc;

   always #2 clk = ~clk;

   vtrans_walker u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i), .acc_i(acc_i),
      .umode_i(umode_i), .sum_i(sum_i), .mxr_i(mxr_i), .root_ppn_i(root_ppn_i),
      .busy_o(busy_o), .mreq_valid_o(mreq_valid_o), .mreq_addr_o(mreq_addr_o),
      .mresp_valid_i(mresp_valid_i), .mresp_err_i(mresp_err_i), .mresp_data_i(mresp_data_i),
      .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o), .level_o(level_o)
   );

   function automatic logic [55:0] ea(input logic [43:0] ppn, input logic [8:0] vpn);
      return {ppn, vpn, 3'b000};
   endfunction
   function automatic logic [63:0] leaf(input logic [43:0] ppn, input int fl);
      return {10'b0, ppn, 10'(fl)};
   endfunction
   function automatic logic [63:0] ptr(input logic [43:0] ppn);
      return {10'b0, ppn, 10'h001};
   endfunction
   function automatic logic [38:0] mkva(input logic [8:0] v2, input logic [8:0] v1,
                                        input logic [8:0] v0, input logic [11:0] off);
      return {v2, v1, v0, off};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   // memory responder: reply one cycle after each request
   initial begin
      forever begin
         @(negedge clk);
         if (mreq_valid_o) begin
            logic [55:0] a;
            a = mreq_addr_o;
            if (nreads < 4) raddr[nreads] = a;
            nreads++;
            @(negedge clk);
            mresp_valid_i = 1'b1;
            mresp_err_i   = (a == err_addr);
            mresp_data_i  = mem.exists(a) ? mem[a] : 64'h0;
            @(negedge clk);
            mresp_valid_i = 1'b0;
            mresp_err_i   = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   task automatic run_walk(input logic [38:0] va, input logic [1:0] acc, input logic um,
                           input logic su, input logic mx, input bit poke);
      nreads = 0;
      @(negedge clk);
      vaddr_i = va; acc_i = acc; umode_i = um; sum_i = su; mxr_i = mx; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      r_cyc = 1;
      while (!done_o && r_cyc < 200) begin
         if (poke && r_cyc == 2) begin
            start_i = 1'b1;
            vaddr_i = ~va;
         end else start_i = 1'b0;
         @(negedge clk);
         r_cyc++;
      end
      start_i = 1'b0;
      if (!done_o) begin
         nerr++;
         $display("FAIL walk timeout: actual none expected done");
      end
      r_fault = fault_o;
      r_pa    = paddr_o;
      r_lvl   = level_o;
   endtask

   task automatic t_reset();
      check("R1 busy", 64'(busy_o), 0);
      check("R1 done", 64'(done_o), 0);
      check("R1 mreq", 64'(mreq_valid_o), 0);
      check("R1 fault", 64'(fault_o), 0);
   endtask

   task automatic t_small_page();
      logic [38:0] va;
      va = mkva(9'd1, 9'd2, 9'd3, 12'h456);
      mem[ea(ROOT, 9'd1)] = ptr(TL1);
      mem[ea(TL1, 9'd2)]  = ptr(TL0);
      mem[ea(TL0, 9'd3)]  = leaf(44'hABCDE, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R3 first read", raddr[0], ea(ROOT, 9'd1));
      check("R4 second read", raddr[1], ea(TL1, 9'd2));
      check("R4 third read", raddr[2], ea(TL0, 9'd3));
      check("R8 4k pa", r_pa, {44'hABCDE, 12'h456});
      check("R8 4k level", r_lvl, 0);
      check("R8 4k fault", r_fault, 0);
      check("R13 3-level latency", r_cyc, 10);
      check("R14 reads", nreads, 3);
   endtask

   task automatic t_superpages();
      logic [38:0] va;
      logic [43:0] gp, mp;
      va = mkva(9'd5, 9'h55, 9'h1AA, 12'h321);
      gp = 44'h40000;
      mem[ea(ROOT, 9'd5)] = leaf(gp, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R8 giga pa", r_pa, {gp[43:18], 9'h55, 9'h1AA, 12'h321});
      check("R8 giga level", r_lvl, 2);
      check("R13 1-level latency", r_cyc, 4);
      mp = 44'h1200;
      mem[ea(ROOT, 9'd5)] = ptr(TL1);
      mem[ea(TL1, 9'h55)] = leaf(mp, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R8 mega pa", r_pa, {mp[43:9], 9'h1AA, 12'h321});
      check("R8 mega level", r_lvl, 1);
      check("R14 mega reads", nreads, 2);
   endtask

   task automatic t_misaligned();
      logic [38:0] va;
      va = mkva(9'd6, 9'd1, 9'd1, 12'h0);
      mem[ea(ROOT, 9'd6)] = leaf(44'h40001, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R9 giga misaligned fault", r_fault, 1);
      check("R13 fault pa zero", r_pa, 0);
      mem[ea(ROOT, 9'd6)] = ptr(TL1);
      mem[ea(TL1, 9'd1)]  = leaf(44'h1201, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R9 mega misaligned fault", r_fault, 1);
   endtask

   task automatic t_ptr_bottom();
      logic [38:0] va;
      va = mkva(9'd7, 9'd8, 9'd9, 12'h0);
      mem[ea(ROOT, 9'd7)] = ptr(TL1);
      mem[ea(TL1, 9'd8)]  = ptr(TL0);
      mem[ea(TL0, 9'd9)]  = ptr(44'h999);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R5 ptr at level 0 fault", r_fault, 1);
      check("R5 reads", nreads, 3);
      check("R5 level", r_lvl, 0);
   endtask

   task automatic t_bad_entries();
      logic [38:0] va;
      va = mkva(9'd8, 9'd0, 9'd0, 12'h0);
      mem[ea(ROOT, 9'd8)] = leaf(44'h40000, FULL & ~FV);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R6 invalid", r_fault, 1);
      mem[ea(ROOT, 9'd8)] = leaf(44'h40000, FV|FW|FA|FD);
      run_walk(va, 2'd1, 0, 0, 0, 0);
      check("R6 W without R", r_fault, 1);
      mem[ea(ROOT, 9'd8)] = leaf(44'h40000, FULL) | (64'h1 << 60);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R6 reserved bit", r_fault, 1);
      mem[ea(ROOT, 9'd8)] = ptr(TL1) | 64'(FA);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R6 pointer with A", r_fault, 1);
      check("R6 pointer with A reads", nreads, 1);
   endtask

   task automatic t_error();
      logic [38:0] va;
      va = mkva(9'd9, 9'd4, 9'd0, 12'h0);
      mem[ea(ROOT, 9'd9)] = ptr(TL1);
      mem[ea(TL1, 9'd4)]  = ptr(TL0);
      err_addr = ea(TL1, 9'd4);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      err_addr = '1;
      check("R7 access fault", r_fault, 2);
      check("R7 reads stop", nreads, 2);
      check("R7 pa zero", r_pa, 0);
   endtask

   task automatic t_priv();
      logic [38:0] va;
      va = mkva(9'd10, 9'd0, 9'd0, 12'h10);
      mem[ea(ROOT, 9'd10)] = leaf(44'h40000, FULL);
      run_walk(va, 2'd0, 1, 0, 0, 0);
      check("R10 user on U=0", r_fault, 1);
      mem[ea(ROOT, 9'd10)] = leaf(44'h40000, FULL | FU);
      run_walk(va, 2'd0, 1, 0, 0, 0);
      check("R10 user on U=1", r_fault, 0);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R10 super load U=1 no sum", r_fault, 1);
      run_walk(va, 2'd0, 0, 1, 0, 0);
      check("R10 super load U=1 sum", r_fault, 0);
      run_walk(va, 2'd2, 0, 1, 0, 0);
      check("R10 super fetch U=1 sum", r_fault, 1);
   endtask

   task automatic t_perm();
      logic [38:0] va;
      va = mkva(9'd11, 9'd0, 9'd0, 12'h0);
      mem[ea(ROOT, 9'd11)] = leaf(44'h40000, FV|FR|FA|FD);
      run_walk(va, 2'd1, 0, 0, 0, 0);
      check("R11 store on read-only", r_fault, 1);
      run_walk(va, 2'd2, 0, 0, 0, 0);
      check("R11 fetch without X", r_fault, 1);
      mem[ea(ROOT, 9'd11)] = leaf(44'h40000, FV|FX|FA|FD);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R11 load X-only no mxr", r_fault, 1);
      run_walk(va, 2'd0, 0, 0, 1, 0);
      check("R11 load X-only mxr", r_fault, 0);
      run_walk(va, 2'd2, 0, 0, 0, 0);
      check("R11 fetch X-only", r_fault, 0);
   endtask

   task automatic t_ad();
      logic [38:0] va;
      va = mkva(9'd12, 9'd0, 9'd0, 12'h0);
      mem[ea(ROOT, 9'd12)] = leaf(44'h40000, FULL & ~FA);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R12 A clear", r_fault, 1);
      mem[ea(ROOT, 9'd12)] = leaf(44'h40000, FULL & ~FD);
      run_walk(va, 2'd1, 0, 0, 0, 0);
      check("R12 store D clear", r_fault, 1);
      run_walk(va, 2'd0, 0, 0, 0, 0);
      check("R12 load D clear", r_fault, 0);
   endtask

   task automatic t_busy_start();
      logic [38:0] va;
      va = mkva(9'd1, 9'd2, 9'd3, 12'h0F0);
      mem[ea(ROOT, 9'd1)] = ptr(TL1);
      mem[ea(TL1, 9'd2)]  = ptr(TL0);
      mem[ea(TL0, 9'd3)]  = leaf(44'h12345, FULL);
      run_walk(va, 2'd0, 0, 0, 0, 1);
      check("R2 result unchanged", r_pa, {44'h12345, 12'h0F0});
      check("R2 reads unchanged", nreads, 3);
      check("R2 first read", raddr[0], ea(ROOT, 9'd1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_page();
      t_superpages();
      t_misaligned();
      t_ptr_bottom();
      t_bad_entries();
      t_error();
      t_priv();
      t_perm();
      t_ad();
      t_busy_start();
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule